// File: doc/BRIEF.md
# Open-LED and Thermal Error Flagger

This block produces the error reporting of a sixteen-channel constant-current LED sink driver. For every channel it receives a flag saying whether the output stage is switched on, and a flag from an external comparator saying whether the output pin voltage is below the open-LED threshold. It also receives a thermal over-limit input, the blanking input and the latch strobe of the serial interface. From these it drives a shared error line as an open-drain pull-down enable with a matching active-low level. It also provides a per-channel open-LED vector and a thermal bit, which the status packet shifts out.

An open-LED error for a channel counts only when three things hold: the channel has been on for a settling window, its pin voltage reads low, and blanking is not active. Blanking forces every output off, so it hides open-LED errors and restarts every settling window. A thermal error is not hidden by blanking. The status bits are sampled once, when the latch strobe falls, and they keep their value until the next fall.

Top module: `led_fault_flagger`

## Requirements
- R1: While reset is low and on the first cycle after it, `err_oe` is 0, `err_n` is 1, `open_status` is all zeros and `therm_status` is 0.
- R2: A channel becomes a qualified open-LED error once `ch_on` has been high and `blank` low for `SETTLE_CYCLES` consecutive rising clock edges, provided its `ch_low` is high at that point.
- R3: A channel that has been on for fewer than `SETTLE_CYCLES` edges never causes an open-LED error, whatever `ch_low` reads.
- R4: `err_oe` is 1 exactly when the thermal flag is set or at least one qualified open-LED error exists, and `err_n` is always its inverse (0 = line pulled low).
- R5: While `blank` is 1, open-LED errors are masked and every settling window restarts from zero. The thermal flag can still drive `err_oe` to 1.
- R6: The thermal flag is `over_temp` registered on the rising clock edge, so it sets and clears one cycle after the input does.
- R7: On the rising clock edge where `latch` is 0 and was 1 on the previous edge, `open_status[i]` loads channel i's qualified open-LED error and `therm_status` loads the thermal flag.
- R8: At every other edge, including while `latch` stays high and at its rising edge, `open_status` and `therm_status` keep their values, independent of live flag changes.
- R9: Taking `ch_on` low for even a single edge restarts that channel's full settling window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_on | input | CHANNELS | Per-channel output-stage-on indication |
| ch_low | input | CHANNELS | Per-channel comparator: pin voltage below open-LED threshold |
| over_temp | input | 1 | Junction over-temperature indication |
| blank | input | 1 | Blanking: all outputs forced off |
| latch | input | 1 | Latch strobe of the serial interface |
| err_n | output | 1 | Active-low error level (1 = released) |
| err_oe | output | 1 | Pull-down enable for the shared open-drain error line |
| open_status | output | CHANNELS | Captured open-LED bit per channel |
| therm_status | output | 1 | Captured thermal bit |

## Verification
A single channel is held on with its comparator low and checked one edge before and one edge at the end of its settling window. A one-edge dropout of `ch_on` then shows that the window truly restarts and does not resume. Every row of the error truth table is driven against a settled channel: thermal set or clear, blanking on or off, and comparator low or high. This separates the thermal path from the masked open-LED path. Latch pulses with long high phases confirm that capture happens only on the falling edge. A long run of random channel, comparator, blanking, thermal and latch activity is then compared against a behavioural model on every clock.

// File: rtl/led_fault_flagger.sv
module led_fault_flagger #(
  parameter int CHANNELS      = 16,
  parameter int SETTLE_CYCLES = 50
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHANNELS-1:0] ch_on,
  input  logic [CHANNELS-1:0] ch_low,
  input  logic                over_temp,
  input  logic                blank,
  input  logic                latch,
  output logic                err_n,
  output logic                err_oe,
  output logic [CHANNELS-1:0] open_status,
  output logic                therm_status
);

  localparam int            CW   = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] CMAX = CW'(SETTLE_CYCLES);

  logic [CW-1:0]       settle_cnt [CHANNELS];
  logic [CHANNELS-1:0] settled;
  logic [CHANNELS-1:0] open_live;
  logic                therm_flag;
  logic                latch_q;
  logic                latch_fall;

  for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n || !ch_on[g] || blank) settle_cnt[g] <= '0;
      else if (!settled[g])             settle_cnt[g] <= settle_cnt[g] + 1'b1;
    end
    assign settled[g] = (settle_cnt[g] == CMAX);

    AST_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_on[g] && !$past(ch_on[g])) |-> !open_live[g]);  // R3
  end

  assign open_live  = settled & ch_on & ch_low & {CHANNELS{~blank}};
  assign latch_fall = latch_q & ~latch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      therm_flag   <= 1'b0;
      latch_q      <= 1'b0;
      open_status  <= '0;
      therm_status <= 1'b0;
    end else begin
      therm_flag <= over_temp;
      latch_q    <= latch;
      if (latch_fall) begin
        open_status  <= open_live;
        therm_status <= therm_flag;
      end
    end
  end

  assign err_oe = therm_flag | (|open_live);
  assign err_n  = ~err_oe;

  AST_THERM_PULLS: assert property (@(posedge clk) disable iff (!rst_n)
    therm_flag |-> !err_n);  // R4
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_on == '0 && !therm_flag) |-> err_n);  // R4
  AST_BLANK_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (blank && !therm_flag) |-> err_n);  // R5
  AST_THERM_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    over_temp |=> !err_n);  // R6
  AST_CAPTURE_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    latch_fall |=> (open_status & ~$past(ch_on & ch_low)) == '0);  // R7
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_fall |=> ($stable(open_status) && $stable(therm_status)));  // R8

endmodule

// File: tb/led_fault_flagger_tb_top.sv
module led_fault_flagger_tb_top;
  localparam int CH = 16;
  localparam int ST = 50;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CH-1:0] ch_on = '0, ch_low = '0;
  logic          over_temp = 1'b0, blank = 1'b0, latch = 1'b0;
  logic          err_n, err_oe, therm_status;
  logic [CH-1:0] open_status;

  int checks = 0, errors = 0;
  bit run_cmp = 1'b0;

  int            m_cnt [CH];
  bit            m_therm, m_latq, m_tst;
  bit [CH-1:0]   m_st;

  always #10 clk = ~clk;

  led_fault_flagger #(.CHANNELS(CH), .SETTLE_CYCLES(ST)) dut_i (
    .clk(clk), .rst_n(rst_n), .ch_on(ch_on), .ch_low(ch_low),
    .over_temp(over_temp), .blank(blank), .latch(latch),
    .err_n(err_n), .err_oe(err_oe),
    .open_status(open_status), .therm_status(therm_status));

  function automatic bit [CH-1:0] m_qual();
    bit [CH-1:0] q;
    for (int i = 0; i < CH; i++)
      q[i] = (m_cnt[i] >= ST) && ch_on[i] && ch_low[i] && !blank;
    return q;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit [CH-1:0] q;
    q = m_qual();
    if (!rst_n) begin
      foreach (m_cnt[i]) m_cnt[i] = 0;
      m_therm = 0; m_latq = 0; m_st = '0; m_tst = 0;
    end else begin
      if (m_latq && !latch) begin m_st = q; m_tst = m_therm; end
      m_therm = over_temp;
      m_latq  = latch;
      for (int i = 0; i < CH; i++)
        if (!ch_on[i] || blank) m_cnt[i] = 0;
        else if (m_cnt[i] < ST) m_cnt[i]++;
    end
  end

  always @(negedge clk) begin
    #2;
    if (run_cmp) begin
      bit e;
      e = m_therm || (|m_qual());
      chk("R4 err_oe", 64'(err_oe), 64'(e));
      chk("R4 err_n", 64'(err_n), 64'(!e));
      chk("R7 open_status", 64'(open_status), 64'(m_st));
      chk("R7 therm_status", 64'(therm_status), 64'(m_tst));
    end
  end

  task automatic cyc(input int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    #3;
    chk("R1 err_n in reset", 64'(err_n), 64'(1));
    chk("R1 status in reset", 64'(open_status), 64'(0));
    rst_n = 1'b1;
    cyc(1); #3;
    chk("R1 err_oe after reset", 64'(err_oe), 64'(0));
    chk("R1 therm_status after reset", 64'(therm_status), 64'(0));
    run_cmp = 1'b1;

    ch_on[3] = 1'b1; ch_low[3] = 1'b1;
    cyc(ST - 1); #3;
    chk("R3 no error before settle", 64'(err_oe), 64'(0));
    cyc(1); #3;
    chk("R2 error after settle", 64'(err_oe), 64'(1));
    chk("R4 err_n low", 64'(err_n), 64'(0));

    ch_on[3] = 1'b0; cyc(1); ch_on[3] = 1'b1;
    cyc(ST - 1); #3;
    chk("R9 window restarted", 64'(err_oe), 64'(0));
    cyc(1); #3;
    chk("R9 settles again", 64'(err_oe), 64'(1));

    for (int t = 0; t < 2; t++)
      for (int l = 0; l < 2; l++) begin
        over_temp = t[0]; ch_low[3] = l[0]; blank = 1'b0;
        cyc(1); #3;
        chk("R4 truth row blank low", 64'(err_oe), 64'(t[0] | l[0]));
        blank = 1'b1; #1;
        chk("R5 truth row blank high", 64'(err_oe), 64'(t[0]));
        blank = 1'b0; cyc(ST);
      end
    over_temp = 1'b1; blank = 1'b1; cyc(1); #3;
    chk("R5 thermal through blank", 64'(err_oe), 64'(1));
    over_temp = 1'b0; cyc(1); #3;
    chk("R6 thermal clears", 64'(err_oe), 64'(0));
    blank = 1'b0; ch_low[3] = 1'b1; cyc(ST - 1); #3;
    chk("R5 blank restarted window", 64'(err_oe), 64'(0));
    cyc(1);

    latch = 1'b1; cyc(5); #3;
    chk("R8 no capture while high", 64'(open_status), 64'(0));
    latch = 1'b0; cyc(1); #3;
    chk("R7 captured on fall", 64'(open_status), 64'(1 << 3));
    ch_on[3] = 1'b0; cyc(3); #3;
    chk("R8 holds after flag drops", 64'(open_status), 64'(1 << 3));

    for (int k = 0; k < 6000; k++) begin
      if ($urandom_range(0, 19) == 0) ch_on[$urandom_range(0, CH - 1)] ^= 1'b1;
      if ($urandom_range(0, 3) == 0) ch_low = CH'($urandom);
      if ($urandom_range(0, 199) == 0) blank = ~blank;
      if ($urandom_range(0, 99) == 0) over_temp = ~over_temp;
      if ($urandom_range(0, 29) == 0) latch = ~latch;
      cyc(1);
    end

    run_cmp = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule